// File: doc/BRIEF.md
# Multi-Mode Histogram Accumulating Buffer

This block is a clocked processing engine built around a 1024-word by 24-bit memory and one shared adder. The same memory and adder serve six streaming functions: counting pixel values into bins, adding a data word into a bin, turning a histogram into a running cumulative sum, storing and reading a lookup table, delaying a sample stream by 1024 samples, and subtracting the delayed sample from the current one. Each function chooses where the memory address comes from and what the adder adds. The address is either the 10-bit pixel input or an internal counter.

The function is picked by a 3-bit code that is captured when the load strobe rises. The capture is accepted only while START is high. Processing runs on every clock while START is low. Each operation's result appears on the registered output two clock edges after its inputs are presented. An active-low flash clear empties the whole memory at once, asynchronously. It does this by dropping one valid bit per word, so that an unwritten word reads as zero. Two of the eight codes hand the memory to a separate host port. In those codes the engine stands idle and raises a flag.

Top module: `histo_accum_buffer`

## Requirements
- R1: The function code on `fct` is taken at the first clock edge that sees `ld` high after it was low, and only if `start` is high at that edge. A rise of `ld` seen while `start` is low leaves the function unchanged. Codes: 000 bin count, 001 cumulative sum, 010 delay-subtract, 011 table, 100 bin add, 101 delay, 110 and 111 host.
- R2: In bin count mode, each clock with `start` low adds 1 to the word at address `pix`. `dout` shows the new count two clock edges after the inputs were presented.
- R3: In bin add mode, each operation adds `din` to the word at address `pix`, modulo 2^24. `dout` shows the new value.
- R4: Operations on the same bin in consecutive clocks all take effect. Each one sees the result of the one before it.
- R5: In cumulative sum mode, the address comes from the counter. Each word is replaced by its own value plus the total written by the previous operation. The first operation, at counter value 0, adds nothing. `dout` shows each written total.
- R6: In table mode with `lutWr` high, `din` is stored at the counter address and echoed on `dout`. With `lutWr` low, the word at address `pix` appears on `dout` two clock edges later.
- R7: In delay mode, the output is the word at the counter address, and that word is then replaced by `din`. Each sample therefore emerges 1024 operations later. Words never written since a clear give 0.
- R8: In delay-subtract mode, the output is `din` minus the stored word, modulo 2^24, and the stored word is replaced by `din`.
- R9: The counter is held at 0 at every clock edge that sees `start` high. It advances by one at every edge with `start` low and wraps from 1023 to 0.
- R10: While `fcN` is low, `dout` is 0, every memory word reads as 0 afterwards, any operation in flight is dropped, and the function returns to bin count. This holds regardless of the clock.
- R11: With code 110 or 111, `hostMode` is high, no operation runs, `dout` holds its value and the memory is unchanged.
- R12: While `start` is high, no operation runs: the memory is unchanged and `dout` holds its value whatever `pix` and `din` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| fcN | input | 1 | Asynchronous active-low flash clear |
| start | input | 1 | Low to process each clock; high to idle and to allow a function change |
| ld | input | 1 | Function code load strobe |
| fct | input | 3 | Function code |
| lutWr | input | 1 | Table mode: high writes, low reads |
| pix | input | 10 | Pixel value used as bin or table address |
| din | input | 24 | Data input |
| dout | output | 24 | Registered result |
| hostMode | output | 1 | High when a host code is selected |

## Verification
The two functions that can meet in one cycle are the flash clear and a read-modify-write that is already in flight. The bench streams counts into one bin. It then pulses `fcN` low between two clock edges, while an earlier count has been captured but not yet written. The dropped count must not reappear: the next two counts must produce 1 and then 2 on `dout`, and a table read of that bin must return 2 while other bins return 0. A second overlap is also checked. A load strobe is raised during a running stream, and the counts must continue unchanged.

// File: rtl/hab_pkg.sv
package hab_pkg;

  // Function codes as seen on the fct input.
  typedef enum logic [2:0] {
    FN_HIST   = 3'b000,
    FN_CDF    = 3'b001,
    FN_DSUB   = 3'b010,
    FN_LUT    = 3'b011,
    FN_BINADD = 3'b100,
    FN_DELAY  = 3'b101,
    FN_HOST24 = 3'b110,
    FN_HOST16 = 3'b111
  } fn_e;

  // Datapath operations chosen by control.
  typedef enum logic [2:0] {
    OP_INC,
    OP_ADDIN,
    OP_CDF,
    OP_LUTW,
    OP_LUTR,
    OP_DELAY,
    OP_DSUB,
    OP_NONE
  } op_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic go;      // an operation is presented this cycle
    logic usePix;  // address from pixel bus, else from counter
    logic first;   // counter is at zero (start of a pass)
    op_e  op;
  } strobe_t;

endpackage

// File: rtl/hab_ctrl.sv
module hab_ctrl
  import hab_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              fcN,
  input  logic              start,
  input  logic              ld,
  input  logic [2:0]        fct,
  input  logic              lutWr,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] cntAddr,
  output logic              hostMode
);

  fn_e               mode;
  logic              ldPrev;
  logic [ADDR_W-1:0] cnt;

  // Function register: load strobe edge detected in the clock domain.
  always_ff @(posedge clk or negedge fcN) begin
    if (!fcN) begin
      mode   <= FN_HIST;
      ldPrev <= 1'b0;
    end else begin
      ldPrev <= ld;
      if (ld && !ldPrev && start) mode <= fn_e'(fct);
    end
  end

  // Address counter: parked at zero while idle, steps while running.
  always_ff @(posedge clk or negedge fcN) begin
    if (!fcN)       cnt <= '0;
    else if (start) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assign cntAddr  = cnt;
  assign hostMode = (mode == FN_HOST24) || (mode == FN_HOST16);

  always_comb begin
    strb.go     = !start && !hostMode;
    strb.first  = (cnt == '0);
    strb.usePix = 1'b0;
    strb.op     = OP_NONE;
    case (mode)
      FN_HIST:   begin strb.op = OP_INC;   strb.usePix = 1'b1; end
      FN_BINADD: begin strb.op = OP_ADDIN; strb.usePix = 1'b1; end
      FN_CDF:    strb.op = OP_CDF;
      FN_DELAY:  strb.op = OP_DELAY;
      FN_DSUB:   strb.op = OP_DSUB;
      FN_LUT: begin
        if (lutWr) strb.op = OP_LUTW;
        else begin strb.op = OP_LUTR; strb.usePix = 1'b1; end
      end
      default:   strb.op = OP_NONE;
    endcase
  end

  AST_CNT_PARK: assert property (@(posedge clk) disable iff (!fcN)
    start |=> (cntAddr == '0)); // R9

  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!fcN)
    !start |=> $stable(mode)); // R1

endmodule

// File: rtl/hab_datapath.sv
module hab_datapath
  import hab_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              fcN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] pix,
  input  logic [ADDR_W-1:0] cntAddr,
  input  logic [DATA_W-1:0] din,
  input  logic              hostMode,
  output logic [DATA_W-1:0] dout
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  wordOk;

  logic              s1Go;
  logic              s1First;
  op_e               s1Op;
  logic [ADDR_W-1:0] s1Addr;
  logic [DATA_W-1:0] s1Din;

  logic [DATA_W-1:0] runTot;
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] sumWord;
  logic [DATA_W-1:0] wData;
  logic [DATA_W-1:0] outNext;
  logic              we;

  // Stage 1: capture operation, address and data.
  always_ff @(posedge clk or negedge fcN) begin
    if (!fcN) begin
      s1Go    <= 1'b0;
      s1First <= 1'b0;
      s1Op    <= OP_NONE;
      s1Addr  <= '0;
      s1Din   <= '0;
    end else begin
      s1Go    <= strb.go;
      s1First <= strb.first;
      s1Op    <= strb.op;
      s1Addr  <= strb.usePix ? pix : cntAddr;
      s1Din   <= din;
    end
  end

  // Read: a word not written since the last clear reads as zero.
  assign rdWord = wordOk[s1Addr] ? mem[s1Addr] : '0;

  // Shared adder operand select.
  always_comb begin
    case (s1Op)
      OP_INC:   addend = DATA_W'(1);
      OP_ADDIN: addend = s1Din;
      OP_CDF:   addend = s1First ? '0 : runTot;
      default:  addend = '0;
    endcase
  end

  assign sumWord = rdWord + addend;

  always_comb begin
    we      = 1'b0;
    wData   = sumWord;
    outNext = dout;
    if (s1Go) begin
      case (s1Op)
        OP_INC, OP_ADDIN, OP_CDF: begin
          we      = 1'b1;
          outNext = sumWord;
        end
        OP_LUTW: begin
          we      = 1'b1;
          wData   = s1Din;
          outNext = s1Din;
        end
        OP_LUTR: outNext = rdWord;
        OP_DELAY: begin
          we      = 1'b1;
          wData   = s1Din;
          outNext = rdWord;
        end
        OP_DSUB: begin
          we      = 1'b1;
          wData   = s1Din;
          outNext = s1Din - rdWord;
        end
        default: outNext = dout;
      endcase
    end
  end

  // Stage 2: memory write, running total and output register.
  always_ff @(posedge clk) begin
    if (we) mem[s1Addr] <= wData;
  end

  always_ff @(posedge clk or negedge fcN) begin
    if (!fcN)    wordOk <= '0;
    else if (we) wordOk[s1Addr] <= 1'b1;
  end

  always_ff @(posedge clk or negedge fcN) begin
    if (!fcN)                          runTot <= '0;
    else if (s1Go && s1Op == OP_CDF)   runTot <= sumWord;
  end

  always_ff @(posedge clk or negedge fcN) begin
    if (!fcN) dout <= '0;
    else      dout <= outNext;
  end

  AST_FLASH_ZERO: assert property (@(posedge clk) disable iff (!fcN)
    $rose(fcN) |-> (dout == '0)); // R10

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!fcN)
    we |=> (wordOk[$past(s1Addr)] && mem[$past(s1Addr)] == $past(wData))); // R6

  AST_HOST_HOLD: assert property (@(posedge clk) disable iff (!fcN)
    hostMode |=> $stable(dout)); // R11

endmodule

// File: rtl/histo_accum_buffer.sv
module histo_accum_buffer
  import hab_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              fcN,
  input  logic              start,
  input  logic              ld,
  input  logic [2:0]        fct,
  input  logic              lutWr,
  input  logic [ADDR_W-1:0] pix,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              hostMode
);

  strobe_t           strb;
  logic [ADDR_W-1:0] cntAddr;

  hab_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .fcN      (fcN),
    .start    (start),
    .ld       (ld),
    .fct      (fct),
    .lutWr    (lutWr),
    .strb     (strb),
    .cntAddr  (cntAddr),
    .hostMode (hostMode)
  );

  hab_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .fcN      (fcN),
    .strb     (strb),
    .pix      (pix),
    .cntAddr  (cntAddr),
    .din      (din),
    .hostMode (hostMode),
    .dout     (dout)
  );

endmodule

// File: tb/histo_accum_buffer_bench.sv
module histo_accum_buffer_bench;

  logic        clk = 1'b0;
  logic        fcN = 1'b1;
  logic        start = 1'b1;
  logic        ld = 1'b0;
  logic [2:0]  fct = 3'b000;
  logic        lutWr = 1'b0;
  logic [9:0]  pix = '0;
  logic [23:0] din = '0;
  logic [23:0] dout;
  logic        hostMode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [9:0]  pA [1100];
  logic [23:0] dA [1100];
  logic [23:0] eA [1100];
  int          n;
  int          ldAt = -1;

  always #5 clk = ~clk;

  histo_accum_buffer u_histo_accum_buffer (
    .clk(clk), .fcN(fcN), .start(start), .ld(ld), .fct(fct), .lutWr(lutWr),
    .pix(pix), .din(din), .dout(dout), .hostMode(hostMode)
  );

  task automatic chk(input logic [23:0] act, input logic [23:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic setMode(input logic [2:0] m);
    @(negedge clk); start = 1'b1; ld = 1'b1; fct = m;
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic flash();
    @(negedge clk); fcN = 1'b0;
    #2 chk(dout, 24'h0, "R10 dout during clear");
    @(negedge clk); fcN = 1'b1;
  endtask

  // Table mode, read side: one read, result two edges later.
  task automatic readBin(input logic [9:0] a, input logic [23:0] exp, input string req);
    @(negedge clk); start = 1'b0; lutWr = 1'b0; pix = a;
    @(negedge clk); start = 1'b1;
    @(negedge clk); chk(dout, exp, req);
  endtask

  // Stream pA/dA for n operations; result of op i sampled at negedge i+2.
  task automatic runStream(input string req);
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (i >= 2) chk(dout, eA[i-2], req);
      if (i == ldAt) begin ld = 1'b1; fct = 3'b101; end
      if (i < n) begin start = 1'b0; pix = pA[i]; din = dA[i]; end
      else start = 1'b1;
    end
    ld = 1'b0;
    ldAt = -1;
  endtask

  task automatic tReset();
    #1 fcN = 1'b0;
    #20;
    chk(dout, 24'h0, "R10 reset dout");
    chk({23'h0, hostMode}, 24'h0, "R1 reset function is bin count");
    fcN = 1'b1;
  endtask

  task automatic tBinCount();
    setMode(3'b000);
    n = 6;
    pA[0] = 5; pA[1] = 5; pA[2] = 5; pA[3] = 7; pA[4] = 5; pA[5] = 1023;
    eA[0] = 1; eA[1] = 2; eA[2] = 3; eA[3] = 1; eA[4] = 4; eA[5] = 1;
    for (int i = 0; i < n; i++) dA[i] = 24'h0;
    runStream("R2/R4 bin count back to back");
    setMode(3'b011);
    readBin(10'd5, 24'd4, "R6 table read of counted bin");
    readBin(10'd1023, 24'd1, "R2 top bin");
  endtask

  task automatic tBinAdd();
    setMode(3'b100);
    n = 3;
    pA[0] = 7; pA[1] = 7; pA[2] = 9;
    dA[0] = 10; dA[1] = 20; dA[2] = 24'hFFFFFF;
    eA[0] = 11; eA[1] = 31; eA[2] = 24'hFFFFFF;
    runStream("R3 bin add");
    setMode(3'b011);
    readBin(10'd7, 24'd31, "R3 bin add stored");
  endtask

  task automatic tCumulative();
    flash();
    setMode(3'b000);
    n = 6;
    pA[0] = 0; pA[1] = 2; pA[2] = 0; pA[3] = 2; pA[4] = 3; pA[5] = 2;
    eA[0] = 1; eA[1] = 1; eA[2] = 2; eA[3] = 2; eA[4] = 1; eA[5] = 3;
    for (int i = 0; i < n; i++) dA[i] = 24'h0;
    runStream("R2 histogram for cumulative");
    setMode(3'b001);
    n = 5;
    for (int i = 0; i < n; i++) begin pA[i] = 10'd900; dA[i] = 24'h0; end
    eA[0] = 2; eA[1] = 2; eA[2] = 5; eA[3] = 6; eA[4] = 6;
    runStream("R5/R9 cumulative sum in counter order");
    setMode(3'b011);
    readBin(10'd0, 24'd2, "R5 stored total bin 0");
    readBin(10'd2, 24'd5, "R5 stored total bin 2");
    readBin(10'd4, 24'd6, "R5 stored total bin 4");
  endtask

  task automatic tTable();
    setMode(3'b011);
    lutWr = 1'b1;
    n = 4;
    for (int i = 0; i < n; i++) begin
      pA[i] = 10'd600; dA[i] = 24'(100 * (i + 1)); eA[i] = dA[i];
    end
    runStream("R6 table write echo");
    lutWr = 1'b0;
    pA[0] = 3; pA[1] = 0; pA[2] = 2; pA[3] = 2;
    eA[0] = 400; eA[1] = 100; eA[2] = 300; eA[3] = 300;
    for (int i = 0; i < n; i++) dA[i] = 24'h0;
    runStream("R6 table read latency two");
  endtask

  task automatic tDelay();
    flash();
    setMode(3'b101);
    n = 1030;
    for (int i = 0; i < n; i++) begin
      pA[i] = '0;
      dA[i] = 24'(i + 1);
      eA[i] = (i < 1024) ? 24'h0 : 24'(i - 1023);
    end
    runStream("R7/R9 delay of 1024 with wrap");
  endtask

  task automatic tDelaySub();
    logic [23:0] a;
    logic [23:0] b;
    setMode(3'b010);
    n = 3;
    pA[0] = 0; pA[1] = 0; pA[2] = 0;
    dA[0] = 5; dA[1] = 2000; dA[2] = 1027;
    a = 24'd5; b = 24'd1025; eA[0] = a - b;
    a = 24'd2000; b = 24'd1026; eA[1] = a - b;
    eA[2] = 24'h0;
    runStream("R8 delay subtract");
    setMode(3'b011);
    readBin(10'd1, 24'd2000, "R8 replaced word");
  endtask

  task automatic tModeLock();
    logic [23:0] held;
    flash();
    setMode(3'b000);
    n = 3;
    for (int i = 0; i < n; i++) begin pA[i] = 10'd40; dA[i] = '0; eA[i] = 24'(i + 1); end
    ldAt = 1;
    runStream("R1 load strobe ignored while running");
    n = 1; pA[0] = 10'd40; eA[0] = 24'd4;
    runStream("R1 function still bin count");
    // Host codes: engine idles.
    setMode(3'b110);
    @(negedge clk);
    chk({23'h0, hostMode}, 24'h1, "R11 host flag");
    held = dout;
    n = 3;
    for (int i = 0; i < n; i++) begin pA[i] = 10'd40; dA[i] = 24'h55; eA[i] = held; end
    runStream("R11 output holds in host code");
    setMode(3'b000);
    chk({23'h0, hostMode}, 24'h0, "R11 host flag drops");
    // Idle with START high: inputs wiggle, nothing changes.
    held = dout;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); start = 1'b1; pix = 10'd40; din = 24'(i);
    end
    @(negedge clk);
    chk(dout, held, "R12 output holds while idle");
    setMode(3'b011);
    readBin(10'd40, 24'd4, "R11/R12 bin unchanged");
  endtask

  task automatic tFlashCollide();
    flash();
    setMode(3'b000);
    @(negedge clk); start = 1'b0; pix = 10'd12;
    @(negedge clk); pix = 10'd12;
    #1 fcN = 1'b0;
    #1 chk(dout, 24'h0, "R10 clear mid stream");
    #1 fcN = 1'b1;
    @(negedge clk); pix = 10'd12;
    @(negedge clk); start = 1'b1;
    chk(dout, 24'd1, "R10 in-flight count dropped");
    @(negedge clk);
    chk(dout, 24'd2, "R10 count after clear");
    setMode(3'b011);
    readBin(10'd12, 24'd2, "R10 bin after collision");
    readBin(10'd40, 24'd0, "R10 other bin cleared");
  endtask

  initial begin
    tReset();
    tBinCount();
    tBinAdd();
    tCumulative();
    tTable();
    tDelay();
    tDelaySub();
    tModeLock();
    tFlashCollide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule